// File: doc/BRIEF.md
# I2C Master Command and FIFO Sequencer

This block is the host-facing half of an I2C master. Software writes a command word that asks for a start condition, an address phase, a stop condition, a direction, a 7-bit target address and a 16-bit byte count. The block then drives a byte-level bus engine. The engine performs a start with address, sends a byte and returns its acknowledge, receives a byte, or ends the transfer. Bit timing and clock division belong to that engine and are not part of this block.

Between the host data port and the bus engine sits an 8-byte FIFO. Two residual counters track progress. The front-end counter falls by one for each byte that crosses the bus. The back-end counter falls by one for each byte the host puts in or takes out. Command-complete is raised when both counters reach zero. Access rules are strict: a FIFO access in the wrong direction, a FIFO access with no transfer open, an overrun, and an access beyond the requested length each set a sticky error bit.

The bus engine handshake is a held request with a one-cycle acknowledge. Only one operation is outstanding at a time. On a send or a start, the acknowledge cycle also carries a nack flag.

Top module: `i2c_cmd_seq`

## Requirements
- R1: The command word is decoded as follows: cmd_word[31] requests start, [30] requests an address phase, [29] is read-continue (ignored), [28] requests stop, [23:17] is the target address, [16] is read-not-write and [15:0] is the byte length. The latched address and direction appear on bus_addr and bus_rnw.
- R2: A command with start, address and stop all clear and a zero length sets err_invalid.
- R3: A command written while cmd_done is low sets err_invalid and leaves the counters and the transfer unchanged.
- R4: An accepted command loads its length into front_left and back_left. If start is requested, cmd_done clears and a start operation (bus_op 0) is issued. A nack on that start sets err_nack, leaves busy low and sets cmd_done again. A successful start raises busy.
- R5: The FIFO holds at most 8 bytes, and fifo_count reports the number of stored entries.
- R6: A host FIFO write with no open transfer, or during a read command, sets err_invalid. A host FIFO read with no open transfer, or during a write command, does the same. In each case the access is dropped.
- R7: A host write to a full FIFO, or a host read from an empty FIFO, is dropped. It sets err_overrun only when pace_allow is low.
- R8: Each accepted host FIFO access lowers back_left by one. If back_left is already zero, err_access is set instead.
- R9: Each byte sent (bus_op 1) or received (bus_op 2) lowers front_left by one. Bytes cross the bus in FIFO order, and bytes read by the host come out in the order they were received.
- R10: A nack on a sent byte sets err_nack and issues an end operation (bus_op 3). When that operation completes, busy clears and cmd_done is set.
- R11: When both counters are zero during an open transfer, the block either ends the transfer or holds it. With stop requested it issues an end operation, and when that completes cmd_done is set and busy clears. Without stop, cmd_done is set and busy stays high, so a later command can continue the same transfer.
- R12: After reset, cmd_done is high, busy is low, all error bits are low and the FIFO is empty. A pulse on err_clr clears the error bits, both counters and the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 32 | Command word |
| pace_allow | input | 1 | Suppress overrun errors on full or empty FIFO access |
| host_wr | input | 1 | Host FIFO write strobe |
| host_wdata | input | 8 | Host FIFO write byte |
| host_rd | input | 1 | Host FIFO read strobe |
| host_rdata | output | 8 | Last byte read by the host |
| err_clr | input | 1 | Clear errors, counters and FIFO |
| cmd_done | output | 1 | Command complete |
| busy | output | 1 | Bus transfer open |
| err_invalid | output | 1 | Invalid command or access |
| err_nack | output | 1 | Nack received |
| err_overrun | output | 1 | FIFO overrun or underrun by host |
| err_access | output | 1 | Host access beyond requested length |
| fifo_count | output | 8 | FIFO entry count |
| front_left | output | 16 | Bus-side residual count |
| back_left | output | 16 | Host-side residual count |
| bus_req | output | 1 | Bus operation request, held until acknowledged |
| bus_op | output | 2 | Operation: 0 start, 1 send, 2 receive, 3 end |
| bus_addr | output | 7 | Target address |
| bus_rnw | output | 1 | Transfer direction, 1 = read |
| bus_wdata | output | 8 | Byte to send (FIFO head) |
| bus_ack | input | 1 | Operation complete |
| bus_nack | input | 1 | Nack, valid with bus_ack |
| bus_rdata | input | 8 | Received byte, valid with bus_ack |

## Verification
Every result of a host strobe is registered. Error bits, counters, fifo_count and host_rdata therefore change on the first rising edge after the strobe, and the bench samples them at the following falling edge. Bus-side results take longer and their timing is fixed. A start request goes out one edge after the command. The engine model acknowledges one edge later, and busy rises on the edge after that. Each data byte then takes three edges: the request, the acknowledgement, and the counter update. The bench waits a fixed number of cycles that covers these stages before sampling. It can also stall data acknowledgements, which freezes the FIFO so that full and empty conditions can be observed.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_END   = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_RUN,
        ST_XFER,
        ST_END
    } seq_state_e;
endpackage

// File: rtl/seq_fifo.sv
module seq_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          push_ok, pop_ok;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem_q[rp_q];
    assign count   = cnt_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        wp_d  = wp_q;
        rp_d  = rp_q;
        cnt_d = cnt_q;
        if (clr) begin
            wp_d  = '0;
            rp_d  = '0;
            cnt_d = '0;
        end else begin
            if (push_ok) wp_d = bump(wp_q);
            if (pop_ok)  rp_d = bump(rp_q);
            case ({push_ok, pop_ok})
                2'b10:   cnt_d = cnt_q + 1'b1;
                2'b01:   cnt_d = cnt_q - 1'b1;
                default: cnt_d = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            wp_q  <= wp_d;
            rp_q  <= rp_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem_q[wp_q] <= wdata;
    end
endmodule

// File: rtl/seq_residual.sv
module seq_residual #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         zero
);
    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                      cnt_d = '0;
        else if (load)                cnt_d = load_val;
        else if (dec && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q;
    assign zero = (cnt_q == '0);
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
    import i2c_seq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7,
    parameter int LEN_W  = 16,
    parameter int STAT_W = 8,
    parameter int CMD_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              pace_allow,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              err_clr,
    output logic              cmd_done,
    output logic              busy,
    output logic              err_invalid,
    output logic              err_nack,
    output logic              err_overrun,
    output logic              err_access,
    output logic [STAT_W-1:0] fifo_count,
    output logic [LEN_W-1:0]  front_left,
    output logic [LEN_W-1:0]  back_left,
    output logic              bus_req,
    output logic [1:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rnw,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_nack,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int CW      = $clog2(DEPTH + 1);
    localparam int NRES    = 2;
    localparam int FRONT   = 0;
    localparam int BACK    = 1;
    localparam int B_START = CMD_W - 1;
    localparam int B_ADDR  = CMD_W - 2;
    localparam int B_STOP  = CMD_W - 4;
    localparam int B_RNW   = LEN_W;
    localparam int B_DEV   = LEN_W + 1;

    typedef struct packed {
        seq_state_e          st;
        logic                busy;
        logic                done;
        logic                e_inv;
        logic                e_nack;
        logic                e_ovr;
        logic                e_acc;
        logic                rnw;
        logic                stop;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   rdata;
        logic                req;
        bus_op_e             op;
    } seq_t;

    seq_t q, n;

    // command field decode
    logic              c_start, c_addr, c_stop, c_rnw;
    logic [ADDR_W-1:0] c_dev;
    logic [LEN_W-1:0]  c_len;
    assign c_start = cmd_word[B_START];
    assign c_addr  = cmd_word[B_ADDR];
    assign c_stop  = cmd_word[B_STOP];
    assign c_rnw   = cmd_word[B_RNW];
    assign c_dev   = cmd_word[B_DEV +: ADDR_W];
    assign c_len   = cmd_word[LEN_W-1:0];

    // FIFO
    logic              f_clr, f_push, f_pop, f_full, f_empty;
    logic              host_push, host_pop, bus_push, bus_pop;
    logic [DATA_W-1:0] f_head, f_wdata;
    logic [CW-1:0]     f_count;

    assign f_push  = host_push | bus_push;
    assign f_pop   = host_pop | bus_pop;
    assign f_wdata = q.rnw ? bus_rdata : host_wdata;

    seq_fifo #(.DEPTH(DEPTH), .DW(DATA_W), .CW(CW)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (f_clr),
        .push  (f_push),
        .wdata (f_wdata),
        .pop   (f_pop),
        .head  (f_head),
        .count (f_count),
        .full  (f_full),
        .empty (f_empty)
    );

    // residual counters: index FRONT = bus side, BACK = host side
    logic [NRES-1:0]  r_load, r_dec, r_zero;
    logic [LEN_W-1:0] r_cnt [NRES];

    for (genvar g = 0; g < NRES; g++) begin : g_res
        seq_residual #(.W(LEN_W)) u_res (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (f_clr),
            .load     (r_load[g]),
            .load_val (c_len),
            .dec      (r_dec[g]),
            .cnt      (r_cnt[g]),
            .zero     (r_zero[g])
        );
    end

    always_comb begin
        n         = q;
        host_push = 1'b0;
        host_pop  = 1'b0;
        bus_push  = 1'b0;
        bus_pop   = 1'b0;
        r_load    = '0;
        r_dec     = '0;
        f_clr     = err_clr;

        if (err_clr) begin
            n.e_inv  = 1'b0;
            n.e_nack = 1'b0;
            n.e_ovr  = 1'b0;
            n.e_acc  = 1'b0;
        end else begin
            if (cmd_wr) begin
                if (!c_start && !c_addr && !c_stop && c_len == '0) begin
                    n.e_inv = 1'b1;
                end else if (!q.done) begin
                    n.e_inv = 1'b1;
                end else begin
                    r_load = '1;
                    n.rnw  = c_rnw;
                    n.stop = c_stop;
                    n.addr = c_dev;
                    if (c_start) begin
                        n.done = 1'b0;
                        n.st   = ST_START;
                        n.req  = 1'b1;
                        n.op   = OP_START;
                    end else if (q.busy) begin
                        n.done = 1'b0;
                    end
                end
            end
            if (host_wr) begin
                if (!q.busy || q.rnw) begin
                    n.e_inv = 1'b1;
                end else if (f_full) begin
                    if (!pace_allow) n.e_ovr = 1'b1;
                end else begin
                    host_push = 1'b1;
                    if (r_zero[BACK]) n.e_acc = 1'b1;
                    else              r_dec[BACK] = 1'b1;
                end
            end
            if (host_rd) begin
                if (!q.busy || !q.rnw) begin
                    n.e_inv = 1'b1;
                end else if (f_empty) begin
                    if (!pace_allow) n.e_ovr = 1'b1;
                end else begin
                    host_pop = 1'b1;
                    n.rdata  = f_head;
                    if (r_zero[BACK]) n.e_acc = 1'b1;
                    else              r_dec[BACK] = 1'b1;
                end
            end
        end

        case (q.st)
            ST_START: begin
                if (bus_ack) begin
                    n.req = 1'b0;
                    if (bus_nack) begin
                        n.e_nack = 1'b1;
                        n.done   = 1'b1;
                        n.busy   = 1'b0;
                        n.st     = ST_IDLE;
                    end else begin
                        n.busy = 1'b1;
                        n.st   = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (!q.done) begin
                    if (r_zero[FRONT] && r_zero[BACK]) begin
                        if (q.stop) begin
                            n.st  = ST_END;
                            n.req = 1'b1;
                            n.op  = OP_END;
                        end else begin
                            n.done = 1'b1;
                        end
                    end else if (!r_zero[FRONT]) begin
                        if (!q.rnw && !f_empty) begin
                            n.st  = ST_XFER;
                            n.req = 1'b1;
                            n.op  = OP_SEND;
                        end else if (q.rnw && !f_full) begin
                            n.st  = ST_XFER;
                            n.req = 1'b1;
                            n.op  = OP_RECV;
                        end
                    end
                end
            end
            ST_XFER: begin
                if (bus_ack) begin
                    n.req        = 1'b0;
                    n.st         = ST_RUN;
                    r_dec[FRONT] = 1'b1;
                    if (q.op == OP_SEND) begin
                        bus_pop = 1'b1;
                        if (bus_nack) begin
                            n.e_nack = 1'b1;
                            n.st     = ST_END;
                            n.req    = 1'b1;
                            n.op     = OP_END;
                        end
                    end else begin
                        bus_push = 1'b1;
                    end
                end
            end
            ST_END: begin
                if (bus_ack) begin
                    n.req  = 1'b0;
                    n.busy = 1'b0;
                    n.done = 1'b1;
                    n.st   = ST_IDLE;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.op   <= OP_START;
            q.done <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign host_rdata  = q.rdata;
    assign cmd_done    = q.done;
    assign busy        = q.busy;
    assign err_invalid = q.e_inv;
    assign err_nack    = q.e_nack;
    assign err_overrun = q.e_ovr;
    assign err_access  = q.e_acc;
    assign fifo_count  = STAT_W'(f_count);
    assign front_left  = r_cnt[FRONT];
    assign back_left   = r_cnt[BACK];
    assign bus_req     = q.req;
    assign bus_op      = q.op;
    assign bus_addr    = q.addr;
    assign bus_rnw     = q.rnw;
    assign bus_wdata   = f_head;
endmodule

// File: rtl/i2c_cmd_seq_chk.sv
module i2c_cmd_seq_chk
    import i2c_seq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              err_clr,
    input logic              cmd_done,
    input logic              busy,
    input logic              err_invalid,
    input logic              err_nack,
    input logic [STAT_W-1:0] fifo_count,
    input logic              bus_req,
    input logic [1:0]        bus_op,
    input logic              bus_ack,
    input logic              bus_nack
);
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= STAT_W'(DEPTH));

    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_op)));

    a_r11_no_data_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && (bus_op == OP_SEND || bus_op == OP_RECV)) |-> !cmd_done);

    a_r6_invalid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_invalid && !err_clr) |=> err_invalid);

    a_r10_nack_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && bus_nack && bus_op == OP_SEND) |=> err_nack);

    a_r11_end_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && bus_op == OP_END) |=> (!busy && cmd_done));
endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk #(.DEPTH(DEPTH), .STAT_W(STAT_W)) u_chk (.*);

// File: tb/i2c_cmd_seq_tb.sv
module i2c_cmd_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        pace_allow = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_rdata;
    logic        err_clr = 1'b0;
    logic        cmd_done, busy, err_invalid, err_nack, err_overrun, err_access;
    logic [7:0]  fifo_count;
    logic [15:0] front_left, back_left;
    logic        bus_req, bus_rnw;
    logic [1:0]  bus_op;
    logic [6:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_ack, bus_nack;
    logic [7:0]  bus_rdata;

    int checks = 0;
    int fails  = 0;

    // bus engine model controls
    logic        stall = 1'b0;
    logic        nack_addr = 1'b0;
    logic        nack_data = 1'b0;
    logic        log_clr = 1'b0;
    logic [7:0]  rd_seed;
    logic [7:0]  sent [16];
    logic [4:0]  sent_n;

    always #10 clk = ~clk;

    i2c_cmd_seq u_dut (.*);

    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_nack  <= 1'b0;
            bus_rdata <= '0;
            rd_seed   <= 8'hA0;
            sent_n    <= '0;
        end else begin
            if (bus_req && !bus_ack && !(stall && (bus_op == 2'd1 || bus_op == 2'd2))) begin
                bus_ack   <= 1'b1;
                bus_nack  <= (bus_op == 2'd0 && nack_addr) || (bus_op == 2'd1 && nack_data);
                bus_rdata <= rd_seed;
                if (bus_op == 2'd2) rd_seed <= rd_seed + 8'd1;
            end else begin
                bus_ack  <= 1'b0;
                bus_nack <= 1'b0;
            end
            if (log_clr) sent_n <= '0;
            else if (bus_req && bus_ack && bus_op == 2'd1) begin
                sent[sent_n[3:0]] <= bus_wdata;
                sent_n <= sent_n + 5'd1;
            end
        end
    end

    function automatic logic [31:0] mk(input logic st, input logic ad, input logic sp,
                                       input logic rnw, input logic [6:0] dev,
                                       input logic [15:0] len);
        return {st, ad, 1'b0, sp, 4'b0000, dev, rnw, len};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic do_cmd(input logic [31:0] w);
        cmd_word = w; cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic do_push(input logic [7:0] b);
        host_wdata = b; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic do_pop();
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic do_clr();
        err_clr = 1'b1; log_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0; log_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 reset done", cmd_done, 1);
        chk("R12 reset busy", busy, 0);
        chk("R12 reset errors", {err_invalid, err_nack, err_overrun, err_access}, 0);
        chk("R12 reset fifo", fifo_count, 0);
    endtask

    task automatic t_invalid();
        do_cmd(mk(0, 0, 0, 0, 7'h12, 16'd0));
        chk("R2 empty command", err_invalid, 1);
        do_clr();
        chk("R12 clear invalid", err_invalid, 0);
        do_push(8'h77);
        chk("R6 write while idle", err_invalid, 1);
        chk("R6 idle write dropped", fifo_count, 0);
        do_clr();
        do_pop();
        chk("R6 read while idle", err_invalid, 1);
        do_clr();
    endtask

    task automatic t_read();
        do_cmd(mk(1, 1, 1, 1, 7'h21, 16'd2));
        wait_n(12);
        chk("R1 addr", bus_addr, 7'h21);
        chk("R1 rnw", bus_rnw, 1);
        chk("R9 rx count", fifo_count, 2);
        chk("R9 front zero", front_left, 0);
        chk("R8 back untouched", back_left, 2);
        chk("R11 not done", cmd_done, 0);
        do_pop();
        chk("R9 first byte", host_rdata, 8'hA0);
        chk("R8 back dec", back_left, 1);
        do_push(8'h01);
        chk("R6 write during read", err_invalid, 1);
        chk("R6 dropped", fifo_count, 1);
        do_pop();
        chk("R9 second byte", host_rdata, 8'hA1);
        wait_n(6);
        chk("R11 done after stop", cmd_done, 1);
        chk("R11 busy clear", busy, 0);
        do_clr();
    endtask

    task automatic t_write();
        do_cmd(mk(1, 1, 1, 0, 7'h50, 16'd3));
        wait_n(5);
        chk("R4 busy", busy, 1);
        chk("R4 front load", front_left, 3);
        chk("R4 back load", back_left, 3);
        do_pop();
        chk("R6 read during write", err_invalid, 1);
        do_push(8'h11); do_push(8'h22); do_push(8'h33);
        wait_n(20);
        chk("R9 sent count", sent_n, 3);
        chk("R9 byte0", sent[0], 8'h11);
        chk("R9 byte1", sent[1], 8'h22);
        chk("R9 byte2", sent[2], 8'h33);
        chk("R11 done", cmd_done, 1);
        chk("R11 released", busy, 0);
        chk("R9 front zero", front_left, 0);
        do_clr();
    endtask

    task automatic t_overrun();
        stall = 1'b1;
        do_cmd(mk(1, 1, 0, 0, 7'h33, 16'd10));
        wait_n(5);
        do_cmd(mk(1, 1, 1, 0, 7'h34, 16'd4));
        chk("R3 busy command", err_invalid, 1);
        chk("R3 count kept", front_left, 10);
        for (int i = 0; i < 8; i++) do_push(8'(i));
        chk("R5 full", fifo_count, 8);
        chk("R7 no overrun yet", err_overrun, 0);
        pace_allow = 1'b1;
        do_push(8'hEE);
        chk("R7 paced no error", err_overrun, 0);
        chk("R7 paced dropped", fifo_count, 8);
        chk("R8 dropped no dec", back_left, 2);
        pace_allow = 1'b0;
        do_push(8'hEF);
        chk("R7 overrun", err_overrun, 1);
        chk("R7 still full", fifo_count, 8);
        stall = 1'b0;
        wait_n(30);
        chk("R9 front after drain", front_left, 2);
        chk("R5 drained", fifo_count, 0);
        do_clr();
        wait_n(3);
        chk("R12 counters cleared", back_left, 0);
        chk("R11 done held open", cmd_done, 1);
        chk("R11 busy held", busy, 1);
        do_cmd(mk(0, 0, 1, 0, 7'h33, 16'd0));
        wait_n(6);
        chk("R11 stop-only ends", busy, 0);
        chk("R11 stop-only done", cmd_done, 1);
        do_clr();
    endtask

    task automatic t_access();
        do_cmd(mk(1, 1, 1, 0, 7'h40, 16'd1));
        wait_n(5);
        do_push(8'hAB);
        do_push(8'hCD);
        chk("R8 access error", err_access, 1);
        wait_n(10);
        chk("R8 one byte sent", sent_n, 1);
        chk("R8 sent value", sent[0], 8'hAB);
        chk("R8 extra left", fifo_count, 1);
        do_clr();
        chk("R12 fifo cleared", fifo_count, 0);
        chk("R12 access cleared", err_access, 0);
    endtask

    task automatic t_empty_read();
        stall = 1'b1;
        do_cmd(mk(1, 1, 0, 1, 7'h22, 16'd3));
        wait_n(6);
        do_pop();
        chk("R7 underrun", err_overrun, 1);
        chk("R8 underrun no dec", back_left, 3);
        stall = 1'b0;
        wait_n(20);
        chk("R9 rx all", fifo_count, 3);
        do_clr();
        wait_n(3);
        do_cmd(mk(0, 0, 1, 1, 7'h22, 16'd0));
        wait_n(6);
        chk("R11 read closed", busy, 0);
        do_clr();
    endtask

    task automatic t_nack();
        nack_addr = 1'b1;
        do_cmd(mk(1, 1, 0, 0, 7'h0F, 16'd1));
        wait_n(6);
        chk("R4 addr nack", err_nack, 1);
        chk("R4 no busy", busy, 0);
        chk("R4 done again", cmd_done, 1);
        nack_addr = 1'b0;
        do_clr();
        nack_data = 1'b1;
        do_cmd(mk(1, 1, 1, 0, 7'h0E, 16'd2));
        wait_n(5);
        do_push(8'h5A);
        do_push(8'h5B);
        wait_n(12);
        chk("R10 data nack", err_nack, 1);
        chk("R10 busy clear", busy, 0);
        chk("R10 done", cmd_done, 1);
        chk("R10 front", front_left, 1);
        chk("R10 one sent", sent_n, 1);
        nack_data = 1'b0;
        do_clr();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        summary();
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_invalid();
        t_read();
        t_write();
        t_overrun();
        t_access();
        t_empty_read();
        t_nack();
        summary();
    end
endmodule